// File: doc/BRIEF.md
# Voltmeter Display Scanner

This block turns an 8-bit conversion result into a 0.00 to 5.00 volt reading on a five-position common-anode seven-segment display. The positions, left to right, are:

- the active channel number;
- a fixed 'C' glyph;
- whole volts, shown with the decimal point lit;
- tenths;
- hundredths.

A free-running tick (a parameter in system clock cycles, nominally 4 ms) refreshes one position per tick. The same tick paces a periodic conversion request to the ADC controller and times the beeper.

Conversion results arrive as a one-cycle `code_valid` pulse with `code_data`. There is no ready signal. The block accepts a result in any cycle, so the producer is never back-pressured. A new result replaces the held one and shows on each position at that position's next refresh.

Two active-low keys pick the channel, which is driven on `adc_chan` for the ADC controller. A press sounds the beeper for a fixed number of ticks. Key input is locked out while the beeper sounds.

Top module: `vmeter_scan`

## Requirements
- R1: Each tick (every `TICK_CYC` clocks) updates `dig_n[7:1]` and `seg_n` together, and both hold between ticks.
  - Positions 0 to 4 are selected in turn.
  - Position k drives `dig_n[7-k]` low and all other bits of `dig_n[7:3]` high.
  - `dig_n[2:1]` stays high.
- R2: The volts digits are taken from the held code c, with S = 51:
  - units = c/S;
  - tenths = ((c mod S)·10)/S;
  - hundredths = ((((c mod S)·10) mod S)·10)/S.
- R3: `seg_n` is active low.
  - Bit 7 is the decimal point.
  - Digits 0 to 9 are C0, F9, A4, B0, 99, 92, 82, F8, 80, 90 (hex), and the 'C' glyph is A7.
- R4: Position contents in order are: channel digit, 'C', units, tenths, hundredths. The decimal point is lit on the units position only.
- R5: `conv_req` is a one-cycle pulse once every `CONV_TICKS` ticks, so consecutive pulses are `CONV_TICKS*TICK_CYC` clocks apart.
- R6: Channel selection:
  - `key0_n` low selects channel 0 and `key1_n` low selects channel 1.
  - If both are low, channel 1 wins.
  - The selection appears on `adc_chan` one clock after the press is sampled.
- R7: The beeper (`dig_n[0]`, active low) behaves as follows:
  - An accepted press drives it low one clock after the press is sampled.
  - It returns high on the `BEEP_TICKS`-th tick after that.
- R8: While the beeper is low, key inputs are ignored and `adc_chan` does not change.
- R9: After reset:
  - `seg_n` and `dig_n` are all ones;
  - `conv_req` is 0;
  - `adc_chan` is 0;
  - the held code is 0.
- R10: A `code_valid` pulse captures `code_data` with no back-pressure. Code 255 reads 5.00 and code 0 reads 0.00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_valid | input | 1 | Conversion result strobe |
| code_data | input | 8 | Conversion result code |
| key0_n | input | 1 | Channel 0 key, active low |
| key1_n | input | 1 | Channel 1 key, active low |
| conv_req | output | 1 | Periodic conversion request pulse |
| adc_chan | output | 1 | Selected channel |
| seg_n | output | 8 | Segment drive, active low, bit 7 is the decimal point |
| dig_n | output | 8 | Position strobes on bits 7:3, bits 2:1 high, beeper on bit 0 |

## Verification
A corrupted position counter shows up as a wrong strobe pattern or a wrong glyph at the very next tick. A frame of five refreshes exposes any misordering. A faulty remainder chain leaves the units digit correct and corrupts only tenths or hundredths, so several codes with different remainders modulo 51 are shown and compared. A wrong beep counter shows as a beeper edge that lands one or more ticks off the 100th strobe change. A broken lockout shows as `adc_chan` moving within one clock of a press made during the beep.

// File: rtl/vmeter_pkg.sv
package vmeter_pkg;
  localparam int NPOS = 5;
  typedef logic [2:0] pos_t;
  localparam pos_t POS_CHAN  = 3'd0;
  localparam pos_t POS_GLYPH = 3'd1;
  localparam pos_t POS_UNIT  = 3'd2;
  localparam pos_t POS_TENTH = 3'd3;
  localparam pos_t POS_HUND  = 3'd4;
  typedef logic [3:0] glyph_t;   // 0..9 decimal digits, 12 = 'C'
  localparam glyph_t GLYPH_C = 4'd12;
endpackage

// File: rtl/vmeter_tick.sv
module vmeter_tick #(
  parameter int TICK_CYC   = 400000,
  parameter int CONV_TICKS = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick,
  output logic conv_req
);
  localparam int CW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam int VW = (CONV_TICKS > 1) ? $clog2(CONV_TICKS) : 1;

  logic [CW-1:0] cyc_q;
  logic [VW-1:0] tk_q;

  assign tick = (cyc_q == CW'(TICK_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q    <= '0;
      tk_q     <= '0;
      conv_req <= 1'b0;
    end else begin
      cyc_q    <= tick ? '0 : cyc_q + 1'b1;
      conv_req <= tick && (tk_q == VW'(CONV_TICKS - 1));
      if (tick) tk_q <= (tk_q == VW'(CONV_TICKS - 1)) ? '0 : tk_q + 1'b1;
    end
  end
endmodule

// File: rtl/vmeter_digits.sv
module vmeter_digits
  import vmeter_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int FULL_VOLTS = 5
) (
  input  logic [CODE_W-1:0] code,
  output glyph_t            units,
  output glyph_t            tenths,
  output glyph_t            hundredths
);
  localparam int unsigned STEP = ((1 << CODE_W) - 1) / FULL_VOLTS;

  int unsigned c_i, rem1, rem2;

  always_comb begin
    c_i        = 32'(code);
    rem1       = (c_i % STEP) * 10;
    rem2       = (rem1 % STEP) * 10;
    units      = glyph_t'(c_i / STEP);
    tenths     = glyph_t'(rem1 / STEP);
    hundredths = glyph_t'(rem2 / STEP);
  end
endmodule

// File: rtl/vmeter_segenc.sv
module vmeter_segenc
  import vmeter_pkg::*;
(
  input  glyph_t     glyph,
  input  logic       dp,
  output logic [7:0] seg_n
);
  logic [7:0] base;

  always_comb begin
    case (glyph)
      4'd0:    base = 8'hC0;
      4'd1:    base = 8'hF9;
      4'd2:    base = 8'hA4;
      4'd3:    base = 8'hB0;
      4'd4:    base = 8'h99;
      4'd5:    base = 8'h92;
      4'd6:    base = 8'h82;
      4'd7:    base = 8'hF8;
      4'd8:    base = 8'h80;
      4'd9:    base = 8'h90;
      GLYPH_C: base = 8'hA7;
      default: base = 8'hFF;
    endcase
    seg_n = dp ? (base & 8'h7F) : base;
  end
endmodule

// File: rtl/vmeter_keys.sv
module vmeter_keys #(
  parameter int BEEP_TICKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic key0_n,
  input  logic key1_n,
  output logic chan,
  output logic beep_on
);
  localparam int BW = $clog2(BEEP_TICKS + 1);

  logic [BW-1:0] cnt_q;
  logic          press;

  assign press = !key0_n || !key1_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan    <= 1'b0;
      beep_on <= 1'b0;
      cnt_q   <= '0;
    end else if (!beep_on) begin
      if (press) begin
        chan    <= !key1_n;      // channel 1 key has priority
        beep_on <= 1'b1;
        cnt_q   <= '0;
      end
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == BW'(BEEP_TICKS - 1)) beep_on <= 1'b0;
    end
  end
endmodule

// File: rtl/vmeter_scan.sv
module vmeter_scan
  import vmeter_pkg::*;
#(
  parameter int TICK_CYC   = 400000,
  parameter int CONV_TICKS = 50,
  parameter int BEEP_TICKS = 100,
  parameter int CODE_W     = 8,
  parameter int FULL_VOLTS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_valid,
  input  logic [CODE_W-1:0] code_data,
  input  logic              key0_n,
  input  logic              key1_n,
  output logic              conv_req,
  output logic              adc_chan,
  output logic [7:0]        seg_n,
  output logic [7:0]        dig_n
);
  logic              tick;
  logic              beep_on;
  logic [CODE_W-1:0] code_q;
  pos_t              pos_q;
  logic [6:0]        strb_q;
  logic [7:0]        seg_q;
  glyph_t            g_units, g_tenths, g_hund, g_cur;
  logic [7:0]        seg_cur;
  logic [7:0]        strb_cur;

  vmeter_tick #(.TICK_CYC(TICK_CYC), .CONV_TICKS(CONV_TICKS)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick), .conv_req(conv_req));

  vmeter_keys #(.BEEP_TICKS(BEEP_TICKS)) u_keys (
    .clk(clk), .rst_n(rst_n), .tick(tick), .key0_n(key0_n), .key1_n(key1_n),
    .chan(adc_chan), .beep_on(beep_on));

  vmeter_digits #(.CODE_W(CODE_W), .FULL_VOLTS(FULL_VOLTS)) u_digits (
    .code(code_q), .units(g_units), .tenths(g_tenths), .hundredths(g_hund));

  always_comb begin
    case (pos_q)
      POS_CHAN:  g_cur = glyph_t'(adc_chan);
      POS_GLYPH: g_cur = GLYPH_C;
      POS_UNIT:  g_cur = g_units;
      POS_TENTH: g_cur = g_tenths;
      default:   g_cur = g_hund;
    endcase
  end

  vmeter_segenc u_seg (.glyph(g_cur), .dp(pos_q == POS_UNIT), .seg_n(seg_cur));

  assign strb_cur = ~(8'h80 >> pos_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      pos_q  <= POS_CHAN;
      strb_q <= 7'h7F;
      seg_q  <= 8'hFF;
    end else begin
      if (code_valid) code_q <= code_data;
      if (tick) begin
        seg_q  <= seg_cur;
        strb_q <= strb_cur[7:1];
        pos_q  <= (pos_q == pos_t'(NPOS - 1)) ? POS_CHAN : pos_q + 1'b1;
      end
    end
  end

  assign seg_n = seg_q;
  assign dig_n = {strb_q, ~beep_on};
endmodule

// File: rtl/vmeter_scan_chk.sv
module vmeter_scan_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       key0_n,
  input logic       key1_n,
  input logic       conv_req,
  input logic       adc_chan,
  input logic [7:0] seg_n,
  input logic [7:0] dig_n
);
  p_one_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dig_n[7:3]) && (dig_n[2:1] == 2'b11));

  p_hold_between_ticks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(dig_n[7:1]) && $stable(seg_n)));

  p_dp_units_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !seg_n[7] |-> !dig_n[5]);

  p_req_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req);

  p_key2_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_n[0] && !key1_n) |=> adc_chan);

  p_beep_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_n[0] && (!key0_n || !key1_n)) |=> !dig_n[0]);

  p_lockout_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dig_n[0] |=> $stable(adc_chan));
endmodule

bind vmeter_scan vmeter_scan_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .key0_n(key0_n), .key1_n(key1_n),
  .conv_req(conv_req), .adc_chan(adc_chan), .seg_n(seg_n), .dig_n(dig_n));

// File: tb/vmeter_scan_bench.sv
module vmeter_scan_bench;
  localparam int TICK  = 4;
  localparam int CONVT = 50;
  localparam int BEEPT = 100;

  typedef struct {
    logic [6:0] strb;
    logic [7:0] seg;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       code_valid = 1'b0;
  logic [7:0] code_data = 8'h00;
  logic       key0_n = 1'b1;
  logic       key1_n = 1'b1;
  logic       conv_req, adc_chan;
  logic [7:0] seg_n, dig_n;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  exp_t exp_q[$];
  logic [6:0] prev_strb = 7'h7F;

  vmeter_scan #(.TICK_CYC(TICK), .CONV_TICKS(CONVT), .BEEP_TICKS(BEEPT)) u_vmeter_scan (
    .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .code_data(code_data),
    .key0_n(key0_n), .key1_n(key1_n), .conv_req(conv_req), .adc_chan(adc_chan),
    .seg_n(seg_n), .dig_n(dig_n));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] glyph_seg(input int g);
    case (g)
      0: return 8'hC0;  1: return 8'hF9;  2: return 8'hA4;  3: return 8'hB0;
      4: return 8'h99;  5: return 8'h92;  6: return 8'h82;  7: return 8'hF8;
      8: return 8'h80;  9: return 8'h90;  default: return 8'hA7;
    endcase
  endfunction

  // monitor: compares each new strobe position against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (dig_n[7:1] != prev_strb && exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(dig_n[7:1] == e.strb, e.tag, "strobe", int'(dig_n[7:1]), int'(e.strb));
        chk(seg_n == e.seg, e.tag, "segments", int'(seg_n), int'(e.seg));
      end
      prev_strb = dig_n[7:1];
    end
  end

  // driver: load a code and expect one full frame of five positions
  task automatic show_code(input int c, input int ch, input string tag);
    int v;
    exp_t e;
    @(negedge clk);
    code_valid = 1'b1; code_data = 8'(c);
    @(negedge clk);
    code_valid = 1'b0;
    while (dig_n[7:1] != 7'b1111011) @(negedge clk);
    @(negedge clk);
    v = (c * 100) / 51;   // reading in hundredths of a volt, truncated
    e.tag = tag;
    e.strb = 7'b0111111; e.seg = glyph_seg(ch);                   exp_q.push_back(e);
    e.strb = 7'b1011111; e.seg = 8'hA7;                           exp_q.push_back(e);
    e.strb = 7'b1101111; e.seg = glyph_seg(v / 100) & 8'h7F;      exp_q.push_back(e);
    e.strb = 7'b1110111; e.seg = glyph_seg((v / 10) % 10);        exp_q.push_back(e);
    e.strb = 7'b1111011; e.seg = glyph_seg(v % 10);               exp_q.push_back(e);
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic wait_beep_end();
    while (!dig_n[0]) @(negedge clk);
  endtask

  initial begin
    int t0, n, k;
    logic [6:0] ps;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state, sampled before the first tick
    chk(seg_n == 8'hFF, "R9", "seg_n", int'(seg_n), 'hFF);
    chk(dig_n == 8'hFF, "R9", "dig_n", int'(dig_n), 'hFF);
    chk(conv_req == 1'b0, "R9", "conv_req", int'(conv_req), 0);
    chk(adc_chan == 1'b0, "R9", "adc_chan", int'(adc_chan), 0);

    // R10 / R2 / R3 / R4: frames for several codes
    show_code(0, 0, "R10");
    show_code(255, 0, "R10");
    show_code(128, 0, "R2");
    show_code(100, 0, "R2");
    show_code(50, 0, "R3");
    show_code(26, 0, "R4");

    // R5: request spacing and width
    while (!conv_req) @(negedge clk);
    t0 = cyc;
    @(negedge clk);
    chk(conv_req == 1'b0, "R5", "pulse width", int'(conv_req), 0);
    while (!conv_req) @(negedge clk);
    chk(cyc - t0 == CONVT * TICK, "R5", "interval", cyc - t0, CONVT * TICK);

    // R6 / R7: channel 1 key
    @(negedge clk);
    key1_n = 1'b0;
    @(negedge clk);
    key1_n = 1'b1;
    chk(adc_chan == 1'b1, "R6", "chan after key1", int'(adc_chan), 1);
    chk(dig_n[0] == 1'b0, "R7", "beep start", int'(dig_n[0]), 0);
    // R8: key0 during beep is ignored; R7: beep length in ticks
    ps = dig_n[7:1]; n = 0; k = 0;
    while (dig_n[0] == 1'b0) begin
      @(negedge clk);
      k++;
      if (k == 1) key0_n = 1'b0;
      if (k == 3) begin
        key0_n = 1'b1;
        chk(adc_chan == 1'b1, "R8", "chan during beep", int'(adc_chan), 1);
      end
      if (dig_n[7:1] != ps) n++;
      ps = dig_n[7:1];
    end
    chk(n == BEEPT, "R7", "ticks until beep ends", n, BEEPT);
    show_code(77, 1, "R6");

    // R6: both keys, channel 1 wins
    @(negedge clk);
    key0_n = 1'b0; key1_n = 1'b0;
    @(negedge clk);
    key0_n = 1'b1; key1_n = 1'b1;
    chk(adc_chan == 1'b1, "R6", "both keys", int'(adc_chan), 1);
    wait_beep_end();
    @(negedge clk);
    key0_n = 1'b0;
    @(negedge clk);
    key0_n = 1'b1;
    chk(adc_chan == 1'b0, "R6", "chan after key0", int'(adc_chan), 0);
    show_code(200, 0, "R6");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule